// File: doc/BRIEF.md
# Master Status and Interrupt Aggregator

This block gives host software one place to look when something changes inside a telecom framer. Eight sources feed one 16-bit status word. One is a boundary tick that the block makes itself by counting receive-clock cycles. The others come from the subsystems around it: saturation of the error counters, a bit-error-rate tester, an HDLC controller, an auxiliary status source, a transmit-clock-loss monitor, a line loss-of-signal monitor and a transmit-driver fault monitor. Each source latches into a bit of its own, and that bit stays set until software reads the word. A read returns the word and clears it in the same cycle. A bit then stays clear until a new event arrives, even if the condition that caused it is still present.

A companion mask word decides which status bits may raise the single active-high interrupt output. Software writes the mask through the same simple strobed port. When the interrupt fires, or when software polls, software reads the status word to learn which subsystem to service. The read also lets the interrupt drop. The length of the boundary period is a parameter, so a simulation can shorten it.

Top module: `msr_aggregator`

## Requirements
- R1: After reset the status word is 0x0500 (bits 8 and 10 set, all others 0), the mask word is 0x0000, `irq` is 0 and `rd_data` is 0x0000.
- R2: Status bits 5, 6, 7, 9, 12, 13, 14 and 15 always read 0. The mask keeps only positions 0–4, 8, 10 and 11 of a written value, so a mask of 0xFFFF reads back as 0x0D1F. A read of any address other than 0x06 and 0x07 returns 0.
- R3: When `rd_stb` is high with `addr` = 0x06, `rd_data` shows the status word on the next cycle and every latched bit is cleared at that same edge. A write to 0x06 has no effect.
- R4: An event that arrives in the same cycle as a clearing read leaves its bit set after the read.
- R5: Bit 0 is set once every `SEC_PERIOD` clock cycles. The first setting happens at the `SEC_PERIOD`-th rising edge after reset is released. After a read clears bit 0, the bit stays clear until the next boundary.
- R6: Bit 1 is set when any bit of `ctr_sat` goes from 0 to 1. A read clears bit 1 even while flags stay high. A falling flag does not set the bit.
- R7: Bit 2 is set by any of these: `bert_sync` going 0→1, `bert_sync` going 1→0, a pulse on `bert_err`, a pulse on `bert_bcnt_ovf`, or a pulse on `bert_ecnt_ovf`. A steady `bert_sync` does not set it.
- R8: A pulse on `hdlc_chg` sets bit 3, and a pulse on `aux_evt` sets bit 4.
- R9: Bit 8 (`tx_clk_loss`), bit 10 (`rx_los`) and bit 11 (`tx_drv_fault`) are set in every cycle in which their input is high. A read made while the input stays high is followed by the bit being set again.
- R10: `irq` is a register that holds the OR of (status AND mask) from the previous cycle. It rises one cycle after an unmasked bit sets, and it falls one cycle after the read that clears the bit.
- R11: The mask word at address 0x07 can be written with `wr_stb` and read back with `rd_stb`. Reading the mask does not change the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; it also times the boundary tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address for a read or a write |
| rd_stb | input | 1 | Read strobe, one cycle wide |
| wr_stb | input | 1 | Write strobe, one cycle wide |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered, valid the cycle after `rd_stb` |
| irq | output | 1 | Active-high interrupt |
| ctr_sat | input | NUM_SAT | Saturation flags of the error counters (levels) |
| bert_sync | input | 1 | Receive-sync state of the bit-error-rate tester (level) |
| bert_err | input | 1 | Bit-error-detected pulse |
| bert_bcnt_ovf | input | 1 | Bit-counter overflow pulse |
| bert_ecnt_ovf | input | 1 | Error-counter overflow pulse |
| hdlc_chg | input | 1 | HDLC controller status-change pulse |
| aux_evt | input | 1 | Auxiliary status-register event pulse |
| tx_clk_loss | input | 1 | Transmit-clock-loss condition (level) |
| rx_los | input | 1 | Line loss-of-signal condition (level) |
| tx_drv_fault | input | 1 | Transmit-driver fault condition (level) |

## Verification
An input change sampled at a rising edge shows in the status word at that edge. It reaches `irq` one edge later, and it reaches `rd_data` at the edge where the read strobe is taken. The bench drives inputs and samples outputs on the falling clock edge. Each read therefore sees `rd_data` and the pre-clear `irq` exactly one falling edge after the strobe, and each `irq` drop is checked one falling edge after that. The boundary tick is timed from a posedge counter that restarts at reset. The bench expects the first observed `irq` at count `SEC_PERIOD`+1 and the second at 2·`SEC_PERIOD`+1, and the table phases finish well before the first boundary.

// File: rtl/msr_pkg.sv
`timescale 1ns/1ps
package msr_pkg;
  localparam int REG_W = 16;

  // bit positions read by host software
  localparam int B_SEC  = 0;
  localparam int B_SAT  = 1;
  localparam int B_PRBS = 2;
  localparam int B_LINK = 3;
  localparam int B_AUX  = 4;
  localparam int B_TCLK = 8;
  localparam int B_LOS  = 10;
  localparam int B_DRV  = 11;

  typedef logic [REG_W-1:0] reg_t;

  typedef struct packed {
    logic sec;
    logic sat;
    logic prbs;
    logic link;
    logic aux;
    logic tclk;
    logic los;
    logic drv;
  } evt_t;

  function automatic reg_t bit_at(int pos);
    reg_t r;
    r = '0;
    r[pos] = 1'b1;
    return r;
  endfunction

  localparam reg_t IMPL_MASK = bit_at(B_SEC) | bit_at(B_SAT) | bit_at(B_PRBS) |
                               bit_at(B_LINK) | bit_at(B_AUX) | bit_at(B_TCLK) |
                               bit_at(B_LOS) | bit_at(B_DRV);
  localparam reg_t RST_VAL   = bit_at(B_TCLK) | bit_at(B_LOS);

  // map named events onto their register positions
  function automatic reg_t place(evt_t e);
    reg_t r;
    r = '0;
    r[B_SEC]  = e.sec;
    r[B_SAT]  = e.sat;
    r[B_PRBS] = e.prbs;
    r[B_LINK] = e.link;
    r[B_AUX]  = e.aux;
    r[B_TCLK] = e.tclk;
    r[B_LOS]  = e.los;
    r[B_DRV]  = e.drv;
    return r;
  endfunction

  // any change worth reporting from the bit-error-rate tester
  function automatic logic prbs_change(logic sync_prev, logic sync_now,
                                       logic err, logic bovf, logic eovf);
    return (sync_prev ^ sync_now) | err | bovf | eovf;
  endfunction

  // clear-on-read with set priority
  function automatic logic next_bit(logic cur, logic set, logic clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_of(reg_t status, reg_t mask);
    return |(status & mask);
  endfunction
endpackage

// File: rtl/msr_sec_timer.sv
`timescale 1ns/1ps
module msr_sec_timer #(
  parameter int PERIOD = 44736000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/msr_event_detect.sv
`timescale 1ns/1ps
module msr_event_detect
  import msr_pkg::*;
#(
  parameter int NUM_SAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [NUM_SAT-1:0] ctr_sat,
  input  logic               bert_sync,
  input  logic               bert_err,
  input  logic               bert_bcnt_ovf,
  input  logic               bert_ecnt_ovf,
  input  logic               hdlc_chg,
  input  logic               aux_evt,
  input  logic               tx_clk_loss,
  input  logic               rx_los,
  input  logic               tx_drv_fault,
  output reg_t               set_vec
);
  logic [NUM_SAT-1:0] sat_q;
  logic               sync_q;
  evt_t               ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      sat_q  <= ctr_sat;
      sync_q <= bert_sync;
    end
  end

  always_comb begin
    ev.sec  = sec_tick;
    ev.sat  = |(ctr_sat & ~sat_q);
    ev.prbs = prbs_change(sync_q, bert_sync, bert_err, bert_bcnt_ovf, bert_ecnt_ovf);
    ev.link = hdlc_chg;
    ev.aux  = aux_evt;
    ev.tclk = tx_clk_loss;
    ev.los  = rx_los;
    ev.drv  = tx_drv_fault;
  end

  assign set_vec = place(ev);
endmodule

// File: rtl/msr_latch_bank.sv
`timescale 1ns/1ps
module msr_latch_bank
  import msr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  reg_t set_vec,
  input  logic clr,
  output reg_t status
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL[i];
      else        q <= IMPL_MASK[i] & next_bit(q, set_vec[i], clr);
    end
    assign status[i] = q;
  end
endmodule

// File: rtl/msr_irq_gen.sv
`timescale 1ns/1ps
module msr_irq_gen
  import msr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  reg_t status,
  input  reg_t mask,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_of(status, mask);
  end
endmodule

// File: rtl/msr_aggregator.sv
`timescale 1ns/1ps
module msr_aggregator
  import msr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STAT_ADDR  = 6,
  parameter int MASK_ADDR  = 7,
  parameter int SEC_PERIOD = 44736000,
  parameter int NUM_SAT    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [15:0]        wr_data,
  output logic [15:0]        rd_data,
  output logic               irq,
  input  logic [NUM_SAT-1:0] ctr_sat,
  input  logic               bert_sync,
  input  logic               bert_err,
  input  logic               bert_bcnt_ovf,
  input  logic               bert_ecnt_ovf,
  input  logic               hdlc_chg,
  input  logic               aux_evt,
  input  logic               tx_clk_loss,
  input  logic               rx_los,
  input  logic               tx_drv_fault
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

  logic sec_tick;
  logic rd_clr;
  logic mask_wr;
  reg_t set_vec;
  reg_t status_q;
  reg_t mask_q;
  reg_t rd_q;

  assign rd_clr  = rd_stb & (addr == A_STAT);
  assign mask_wr = wr_stb & (addr == A_MASK);

  msr_sec_timer #(.PERIOD(SEC_PERIOD)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sec_tick)
  );

  msr_event_detect #(.NUM_SAT(NUM_SAT)) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_tick     (sec_tick),
    .ctr_sat      (ctr_sat),
    .bert_sync    (bert_sync),
    .bert_err     (bert_err),
    .bert_bcnt_ovf(bert_bcnt_ovf),
    .bert_ecnt_ovf(bert_ecnt_ovf),
    .hdlc_chg     (hdlc_chg),
    .aux_evt      (aux_evt),
    .tx_clk_loss  (tx_clk_loss),
    .rx_los       (rx_los),
    .tx_drv_fault (tx_drv_fault),
    .set_vec      (set_vec)
  );

  msr_latch_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr    (rd_clr),
    .status (status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wr_data & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_stb) begin
      if (addr == A_STAT)      rd_q <= status_q;
      else if (addr == A_MASK) rd_q <= mask_q;
      else                     rd_q <= '0;
    end
  end

  assign rd_data = rd_q;

  msr_irq_gen u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .status(status_q),
    .mask  (mask_q),
    .irq   (irq)
  );
endmodule

// File: rtl/msr_aggregator_chk.sv
`timescale 1ns/1ps
module msr_aggregator_chk
  import msr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input reg_t        status,
  input reg_t        mask,
  input reg_t        set_vec,
  input logic        rd_clr,
  input logic        sec_tick,
  input logic        irq,
  input logic [15:0] rd_data
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == '0) |=> (status == '0)); // R3

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && set_vec == '0) |=> $stable(status)); // R3

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(status) & $past(mask)))); // R10

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & ~IMPL_MASK) == '0) && ((mask & ~IMPL_MASK) == '0)); // R2

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick); // R5
endmodule

bind msr_aggregator msr_aggregator_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .status  (status_q),
  .mask    (mask_q),
  .set_vec (set_vec),
  .rd_clr  (rd_clr),
  .sec_tick(sec_tick),
  .irq     (irq),
  .rd_data (rd_data)
);

// File: tb/test_msr_aggregator.sv
`timescale 1ns/1ps
module test_msr_aggregator;
  localparam int P    = 200;
  localparam int NSAT = 2;
  localparam logic [7:0] A_ST = 8'h06;
  localparam logic [7:0] A_MK = 8'h07;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic irq;
  logic [NSAT-1:0] ctr_sat = '0;
  logic bert_sync = 0, bert_err = 0, bert_bcnt_ovf = 0, bert_ecnt_ovf = 0;
  logic hdlc_chg = 0, aux_evt = 0, tx_clk_loss = 0, rx_los = 0, tx_drv_fault = 0;

  int n_cmp = 0, n_bad = 0;
  int ncyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) ncyc <= rst_n ? ncyc + 1 : 0;

  msr_aggregator #(.SEC_PERIOD(P), .NUM_SAT(NSAT)) i_msr_aggregator (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .ctr_sat(ctr_sat),
    .bert_sync(bert_sync), .bert_err(bert_err), .bert_bcnt_ovf(bert_bcnt_ovf),
    .bert_ecnt_ovf(bert_ecnt_ovf), .hdlc_chg(hdlc_chg), .aux_evt(aux_evt),
    .tx_clk_loss(tx_clk_loss), .rx_los(rx_los), .tx_drv_fault(tx_drv_fault)
  );

  // row: {mask[15:0], pulses[7:0], sync, sat[1:0], exp_rd[15:0], exp_irq}
  // pulses = {drv, los, tclk, ecnt_ovf, bcnt_ovf, bit_err, aux, hdlc}
  localparam int NV = 18;
  localparam logic [43:0] VEC [NV] = '{
    {16'hFFFF, 8'h01, 1'b0, 2'b00, 16'h0008, 1'b1},  // R8 hdlc
    {16'h0000, 8'h02, 1'b0, 2'b00, 16'h0010, 1'b0},  // R8 aux, masked
    {16'h0010, 8'h02, 1'b0, 2'b00, 16'h0010, 1'b1},  // R8 aux
    {16'h0004, 8'h04, 1'b0, 2'b00, 16'h0004, 1'b1},  // R7 bit error
    {16'h0004, 8'h08, 1'b0, 2'b00, 16'h0004, 1'b1},  // R7 bit counter ovf
    {16'h0004, 8'h10, 1'b0, 2'b00, 16'h0004, 1'b1},  // R7 error counter ovf
    {16'h0004, 8'h00, 1'b1, 2'b00, 16'h0004, 1'b1},  // R7 sync rise
    {16'h0004, 8'h00, 1'b1, 2'b00, 16'h0000, 1'b0},  // R7 sync steady
    {16'h0004, 8'h00, 1'b0, 2'b00, 16'h0004, 1'b1},  // R7 sync fall
    {16'h0002, 8'h00, 1'b0, 2'b01, 16'h0002, 1'b1},  // R6 first rise
    {16'h0002, 8'h00, 1'b0, 2'b01, 16'h0000, 1'b0},  // R6 still saturated
    {16'h0002, 8'h00, 1'b0, 2'b11, 16'h0002, 1'b1},  // R6 second rise
    {16'h0002, 8'h00, 1'b0, 2'b00, 16'h0000, 1'b0},  // R6 falls
    {16'h0100, 8'h20, 1'b0, 2'b00, 16'h0100, 1'b1},  // R9 tclk
    {16'h0400, 8'h40, 1'b0, 2'b00, 16'h0400, 1'b1},  // R9 los
    {16'h0800, 8'h80, 1'b0, 2'b00, 16'h0800, 1'b1},  // R9 drv
    {16'h00E0, 8'h06, 1'b0, 2'b00, 16'h0014, 1'b0},  // R2 unused mask bits
    {16'h0D1F, 8'hFF, 1'b1, 2'b00, 16'h0D1C, 1'b1}   // R10 all sources
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [15:0] d);
    addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, output logic [15:0] d);
    addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] d;
    do_reset();
    @(negedge clk);
    // reset state
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    do_read(A_MK, d); check("R1 mask", d, 16'h0000);
    do_read(A_ST, d); check("R1 status", d, 16'h0500);
    do_read(A_ST, d); check("R3 cleared", d, 16'h0000);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      do_write(A_MK, v[43:28]);
      {tx_drv_fault, rx_los, tx_clk_loss, bert_ecnt_ovf, bert_bcnt_ovf,
       bert_err, aux_evt, hdlc_chg} = v[27:20];
      bert_sync = v[19];
      ctr_sat   = v[18:17];
      @(negedge clk);
      {tx_drv_fault, rx_los, tx_clk_loss, bert_ecnt_ovf, bert_bcnt_ovf,
       bert_err, aux_evt, hdlc_chg} = 8'h00;
      do_read(A_ST, d);
      check($sformatf("row %0d status (R3/R6/R7/R8/R9)", i), d, v[16:1]);
      check($sformatf("row %0d irq R10", i), {15'd0, irq}, {15'd0, v[0]});
      @(negedge clk);
    end
    bert_sync = 1'b0;

    // directed corner cases
    do_reset();
    @(negedge clk);
    do_read(A_ST, d);
    // R4: event in the same cycle as the clearing read
    addr = A_ST; rd_stb = 1'b1; hdlc_chg = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; hdlc_chg = 1'b0;
    check("R4 read during event", rd_data, 16'h0000);
    do_read(A_ST, d); check("R4 event kept", d, 16'h0008);
    // R3: writes to the status address are ignored
    do_write(A_ST, 16'hFFFF);
    do_read(A_ST, d); check("R3 write ignored", d, 16'h0000);
    // R9: level input persists across reads
    rx_los = 1'b1;
    @(negedge clk);
    do_read(A_ST, d); check("R9 level first", d, 16'h0400);
    do_read(A_ST, d); check("R9 level re-set", d, 16'h0400);
    rx_los = 1'b0;
    do_read(A_ST, d); check("R9 last set", d, 16'h0400);
    do_read(A_ST, d); check("R9 gone", d, 16'h0000);
    // R10: irq latency on set and clear
    do_write(A_MK, 16'h0008);
    hdlc_chg = 1'b1;
    @(negedge clk);
    hdlc_chg = 1'b0;
    check("R10 irq not yet", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R10 irq rises", {15'd0, irq}, 16'h0001);
    do_read(A_ST, d);
    check("R10 irq during read", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    check("R10 irq falls", {15'd0, irq}, 16'h0000);
    // R11 / R2: mask readback and unmapped address
    do_write(A_MK, 16'hFFFF);
    do_read(A_MK, d); check("R11 mask readback", d, 16'h0D1F);
    do_read(8'h20, d); check("R2 unmapped", d, 16'h0000);

    // R5: boundary tick timing
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; addr = A_MK; wr_data = 16'h0001; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    while (!irq && ncyc < 3 * P) @(negedge clk);
    check("R5 first tick", 16'(ncyc), 16'(P + 1));
    do_read(A_ST, d); check("R5 tick in status", d, 16'h0501);
    do_read(A_ST, d); check("R5 not set again", d, 16'h0000);
    @(negedge clk);
    while (!irq && ncyc < 4 * P) @(negedge clk);
    check("R5 second tick", 16'(ncyc), 16'(2 * P + 1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule